// File: doc/BRIEF.md
# TDM Multichannel Transmit Slot Controller

This block drives the transmit side of a time-division-multiplexed serial link that carries up to 128 channel slots in each frame. A frame sync pulse restarts a slot counter at slot 0. Each slot then lasts one word time, and its bits go out most significant bit first. Two banks of per-slot bit masks control each slot. The select bank decides whether the slot drives the data pin or leaves it released. The compand bank decides whether the outgoing sample is first converted to an 8-bit mu-law code.

Software loads the masks through a simple write port, one 32-bit word at a time. A write lands in a pending copy, and that copy becomes active only at the next frame sync, so a frame never sees a mask change partway through. Samples arrive on a ready/valid port. The block takes a word only for a slot it is going to drive. If no sample is waiting at that moment, the slot carries zeros and a sticky underflow flag is set. A status output shows the slot now on the wire and keeps its value once the frame has ended.

A global multichannel enable input is sampled at the start of each slot. While it is low, no slot is driven and no sample is taken.

Top module: `tdm_tx_slot`

## Requirements
- R1: After reset, `sd_oe_o`, `sd_o`, `in_ready_o` and `underflow_o` are low and `cur_slot_o` is 0.
- R2: When `fsync_i` is high at a clock edge, slot 0 begins. Its first bit is on `sd_o` in the next cycle. Every slot lasts DATA_W cycles, and slots follow one another in increasing order with no gap.
- R3: A slot whose select bit is 1 while `mc_en_i` is high at the slot's start is driven. For such a slot, `in_ready_o` is high in the cycle just before the slot's first bit, and exactly one word is taken. `sd_oe_o` is high for all DATA_W cycles of the slot, and the word leaves MSB first. Channel c is controlled by bit c mod 32 of the select word written with `cfg_idx_i` = c div 32 and `cfg_bank_i` = 0.
- R4: A slot whose select bit is 0 keeps `sd_oe_o` and `sd_o` low for the whole slot, and no word is taken for it.
- R5: When a driven slot's compand bit is 1 (written with `cfg_bank_i` = 1, same channel mapping as R3), the transmitted word is the 8-bit mu-law code in the top 8 bits, followed by zeros. The code is formed as follows. Take the magnitude of the signed 16-bit sample and clip it at 32635. Add 132. Let e (0..7) be the highest set bit position minus 7. The mantissa m is 4 bits: the sum shifted right by e+3. The code is the bitwise inverse of {sign, e, m}.
- R6: A slot that starts while `mc_en_i` is low is not driven and takes no word.
- R7: After the last slot (the `last_slot_i` value sampled at frame sync) has finished, `sd_oe_o` and `in_ready_o` stay low until the next frame sync.
- R8: `cur_slot_o` shows the index of the slot being sent. After the frame ends, it keeps the last slot's index.
- R9: A driven slot that starts with `in_valid_i` low sends all zeros with `sd_oe_o` high. It also sets `underflow_o`, which then stays high until reset.
- R10: A mask write changes nothing in the frame in progress. It takes effect from the next frame sync onward.
- R11: A frame sync that arrives during a frame restarts the sequence at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync pulse; restarts at slot 0 |
| mc_en_i | input | 1 | Multichannel enable, sampled at each slot start |
| last_slot_i | input | 7 | Index of the final slot in a frame, sampled at frame sync |
| cfg_we_i | input | 1 | Mask word write strobe |
| cfg_bank_i | input | 1 | Mask bank: 0 = select, 1 = compand |
| cfg_idx_i | input | 2 | Mask word index (channels 32*idx .. 32*idx+31) |
| cfg_data_i | input | 32 | Mask word value |
| in_valid_i | input | 1 | Sample available |
| in_data_i | input | 16 | Signed linear sample |
| in_ready_o | output | 1 | Sample taken at this edge when valid |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Drive enable for the data pin |
| cur_slot_o | output | 7 | Current (held) slot index |
| underflow_o | output | 1 | Sticky sample underflow flag |

## Verification
The bench builds the block with its default values: 128 slots and 16-bit words. This allows a full-length frame that reaches slot 127 and all four mask words of each bank, including slot 32, the first channel in the second word. Sample values include the most negative and most positive 16-bit numbers, so the compander's clipping and sign handling are exercised. The bench also runs frames cut short by an early frame sync, frames that receive a mask write partway through, and frames with no samples supplied.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int CFG_W  = 32;
  localparam int CODE_W = 8;

  typedef enum logic {
    BANK_SELECT  = 1'b0,
    BANK_COMPAND = 1'b1
  } cfg_bank_e;

  // 16-bit signed linear sample to 8-bit mu-law code
  function automatic logic [CODE_W-1:0] mulaw_encode(input logic [15:0] lin);
    logic        sign;
    logic [16:0] mag;
    logic [15:0] biased;
    logic [2:0]  expo;
    logic [3:0]  mant;
    sign = lin[15];
    mag  = sign ? ({1'b0, ~lin} + 17'd1) : {1'b0, lin};
    if (mag > 17'd32635) mag = 17'd32635;
    biased = 16'(mag) + 16'd132;
    expo = '0;
    for (int i = 0; i < 8; i++) begin
      if (biased[7+i]) expo = 3'(i);
    end
    mant = 4'(biased >> ({1'b0, expo} + 4'd3));
    return ~{sign, expo, mant};
  endfunction

endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/tdm_mask_bank.sv
module tdm_mask_bank #(
  parameter int NUM_SLOTS = 128,
  parameter int REG_W     = 32,
  localparam int NUM_REGS = NUM_SLOTS / REG_W,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [REG_W-1:0]     data_i,
  input  logic                 commit_i,
  output logic [NUM_SLOTS-1:0] mask_o
);

  logic [NUM_REGS-1:0][REG_W-1:0] pend_q, pend_d;
  logic [NUM_REGS-1:0][REG_W-1:0] act_q, act_d;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    assign pend_d[r] = (we_i && (idx_i == IDX_W'(r))) ? data_i : pend_q[r];
  end

  // frame sync moves the pending copy into service
  assign act_d  = commit_i ? pend_q : act_q;
  // mask seen by a slot being loaded in this cycle
  assign mask_o = act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i)     pend_q <= pend_d;
      if (commit_i) act_q  <= act_d;
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(act_q)) else $error("mask changed without frame sync"); // R10

endmodule

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
  parameter int NUM_SLOTS = 128,
  parameter int SLOT_LEN  = 16,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int BW = $clog2(SLOT_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync_i,
  input  logic [SW-1:0] last_slot_i,
  output logic          run_o,
  output logic [SW-1:0] slot_o,
  output logic          load_o,
  output logic [SW-1:0] load_slot_o
);

  logic          run_q, run_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] last_q, last_d;
  logic          end_bit, at_last, seq_en;

  always_comb begin
    end_bit     = run_q && (bit_q == BW'(SLOT_LEN-1));
    at_last     = (slot_q == last_q);
    load_o      = fsync_i || (end_bit && !at_last);
    load_slot_o = fsync_i ? '0 : slot_q + SW'(1);
    seq_en      = fsync_i || run_q;
    run_d  = run_q;
    slot_d = slot_q;
    bit_d  = bit_q;
    last_d = last_q;
    if (fsync_i) begin
      run_d  = 1'b1;
      slot_d = '0;
      bit_d  = '0;
      last_d = (last_slot_i > SW'(NUM_SLOTS-1)) ? SW'(NUM_SLOTS-1) : last_slot_i;
    end else if (end_bit) begin
      bit_d = '0;
      if (at_last) run_d  = 1'b0;
      else         slot_d = slot_q + SW'(1);
    end else if (run_q) begin
      bit_d = bit_q + BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
      last_q <= '0;
    end else if (seq_en) begin
      run_q  <= run_d;
      slot_q <= slot_d;
      bit_q  <= bit_d;
      last_q <= last_d;
    end
  end

  assign run_o  = run_q;
  assign slot_o = slot_q;

  AST_FSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_i |=> (run_q && slot_q == '0 && bit_q == '0)) else $error("no restart"); // R11
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (end_bit && !at_last && !fsync_i) |=> (slot_q == $past(slot_q) + SW'(1))) else $error("slot skip"); // R2
  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (slot_q <= last_q)) else $error("slot past last"); // R7
  AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !fsync_i) |=> $stable(slot_q)) else $error("idle slot moved"); // R8

endmodule

// File: rtl/tdm_word_shifter.sv
module tdm_word_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              drive_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o,
  output logic              drive_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              drv_q, drv_d;
  logic              sh_en;

  always_comb begin
    sh_en = load_i || shift_i;
    sh_d  = load_i ? word_i : {sh_q[DATA_W-2:0], 1'b0};
    drv_d = load_i ? drive_i : drv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      drv_q <= 1'b0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      drv_q <= drv_d;
    end
  end

  assign bit_o   = sh_q[DATA_W-1];
  assign drive_o = drv_q;

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (bit_o == $past(word_i[DATA_W-1]))) else $error("MSB not first"); // R3
  AST_DRIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(drive_o)) else $error("drive changed mid slot"); // R4

endmodule

// File: rtl/tdm_tx_slot.sv
module tdm_tx_slot
  import tdm_tx_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int DATA_W    = 16,
  localparam int SW       = $clog2(NUM_SLOTS),
  localparam int NUM_REGS = NUM_SLOTS / CFG_W,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              mc_en_i,
  input  logic [SW-1:0]     last_slot_i,
  input  logic              cfg_we_i,
  input  logic              cfg_bank_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic [SW-1:0]     cur_slot_o,
  output logic              underflow_o
);

  logic                 rst_sync_n;
  logic [NUM_SLOTS-1:0] sel_mask, cmp_mask;
  logic                 sel_we, cmp_we;
  logic                 run, load;
  logic [SW-1:0]        slot, load_slot;
  logic                 drive_nx, cmp_nx, starve;
  logic [DATA_W-1:0]    comp_word, word_nx;
  logic                 tx_bit, tx_drive;
  logic                 uflow_q, uflow_d;

  tdm_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  assign sel_we = cfg_we_i && (cfg_bank_e'(cfg_bank_i) == BANK_SELECT);
  assign cmp_we = cfg_we_i && (cfg_bank_e'(cfg_bank_i) == BANK_COMPAND);

  tdm_mask_bank #(.NUM_SLOTS(NUM_SLOTS), .REG_W(CFG_W)) i_sel_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we_i     (sel_we),
    .idx_i    (cfg_idx_i),
    .data_i   (cfg_data_i),
    .commit_i (fsync_i),
    .mask_o   (sel_mask)
  );

  tdm_mask_bank #(.NUM_SLOTS(NUM_SLOTS), .REG_W(CFG_W)) i_cmp_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .we_i     (cmp_we),
    .idx_i    (cfg_idx_i),
    .data_i   (cfg_data_i),
    .commit_i (fsync_i),
    .mask_o   (cmp_mask)
  );

  tdm_slot_seq #(.NUM_SLOTS(NUM_SLOTS), .SLOT_LEN(DATA_W)) i_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .fsync_i     (fsync_i),
    .last_slot_i (last_slot_i),
    .run_o       (run),
    .slot_o      (slot),
    .load_o      (load),
    .load_slot_o (load_slot)
  );

  always_comb begin
    drive_nx   = mc_en_i && sel_mask[load_slot];
    cmp_nx     = cmp_mask[load_slot];
    in_ready_o = load && drive_nx;
    starve     = in_ready_o && !in_valid_i;
    comp_word  = {mulaw_encode(in_data_i[DATA_W-1 -: 16]), {(DATA_W-CODE_W){1'b0}}};
    if (!drive_nx || !in_valid_i) word_nx = '0;
    else if (cmp_nx)              word_nx = comp_word;
    else                          word_nx = in_data_i;
    uflow_d = uflow_q || starve;
  end

  tdm_word_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (load),
    .shift_i (run),
    .drive_i (drive_nx),
    .word_i  (word_nx),
    .bit_o   (tx_bit),
    .drive_o (tx_drive)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) uflow_q <= 1'b0;
    else if (starve) uflow_q <= uflow_d;
  end

  assign sd_oe_o     = run && tx_drive;
  assign sd_o        = sd_oe_o && tx_bit;
  assign cur_slot_o  = slot;
  assign underflow_o = uflow_q;

  AST_POP_DRIVES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready_o && in_valid_i) |=> sd_oe_o) else $error("taken word not driven"); // R3
  AST_MC_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && !mc_en_i) |=> !sd_oe_o) else $error("slot driven while disabled"); // R6
  AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!run && !fsync_i) |-> !in_ready_o) else $error("take outside frame"); // R7
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    underflow_o |=> underflow_o) else $error("underflow cleared"); // R9
  AST_STARVE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready_o && !in_valid_i) |=> (sd_oe_o && !sd_o)) else $error("starved slot not zero"); // R9

endmodule

// File: tb/test_tdm_tx_slot.sv
module test_tdm_tx_slot;

  localparam int NS = 128;
  localparam int DW = 16;
  localparam int SW = 7;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fsync = 1'b0;
  logic          mc_en = 1'b0;
  logic [SW-1:0] last_slot = '0;
  logic          cfg_we = 1'b0;
  logic          cfg_bank = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [31:0]   cfg_data = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, sd_o, sd_oe, uflow;
  logic [SW-1:0] cur_slot;

  tdm_tx_slot i_tdm_tx_slot (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .mc_en_i(mc_en),
    .last_slot_i(last_slot), .cfg_we_i(cfg_we), .cfg_bank_i(cfg_bank),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .sd_o(sd_o), .sd_oe_o(sd_oe),
    .cur_slot_o(cur_slot), .underflow_o(uflow)
  );

  always #4 clk = ~clk;

  // kind: 0 off (R4), 1 plain (R3), 2 compand (R5), 3 starved (R9), 4 mc off (R6)
  typedef struct packed {
    logic [SW-1:0] slot;
    logic          drive;
    logic [2:0]    kind;
    logic [DW-1:0] word;
  } exp_t;

  exp_t          exp_q[$];
  logic [DW-1:0] src_q[$];
  logic [NS-1:0] sel_pend = '0, sel_act = '0, cmp_pend = '0, cmp_act = '0;
  int            n_checks = 0, n_fail = 0;
  int            frame_last = 0;
  bit            mon_on = 0, mon_act = 0, mon_oe_bad = 0, pop_pend = 0;
  int            mon_bit = 0, mon_slot = 0;
  logic [DW-1:0] mon_acc = '0;
  logic [31:0]   lcg = 32'h1234_5678;
  int            wcount = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic string kind_req(input logic [2:0] k);
    case (k)
      3'd0: return "R4";
      3'd1: return "R3";
      3'd2: return "R5";
      3'd3: return "R9";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] mu_ref(input logic [15:0] x);
    int v, s, e, m;
    v = int'($signed(x));
    s = (v < 0) ? 1 : 0;
    if (s == 1) v = -v;
    if (v > 32635) v = 32635;
    v = v + 132;
    e = 7;
    while (e > 0 && ((v >> (e + 7)) & 1) == 0) e--;
    m = (v >> (e + 3)) & 15;
    return ~8'(s * 128 + e * 16 + m);
  endfunction

  function automatic logic [DW-1:0] next_word();
    logic [DW-1:0] w;
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    case (wcount % 6)
      0: w = 16'h8000;
      1: w = 16'h7FFF;
      2: w = 16'hFF80;
      default: w = lcg[23:8];
    endcase
    wcount++;
    return w;
  endfunction

  task automatic refresh_src();
    in_valid = (src_q.size() > 0);
    in_data  = (src_q.size() > 0) ? src_q[0] : '0;
  endtask

  // input feeder: applies takes seen before the edge
  always @(posedge clk) begin
    #1;
    if (pop_pend) begin
      if (src_q.size() > 0) void'(src_q.pop_front());
      pop_pend = 0;
    end
    refresh_src();
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (mon_on) begin
      pop_pend = in_ready && in_valid;
      if (mon_act) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", "slot with no expectation", mon_slot, -1);
          mon_act = 0;
        end else begin
          e = exp_q[0];
          if (sd_oe !== e.drive) mon_oe_bad = 1;
          mon_acc = {mon_acc[DW-2:0], sd_o};
          mon_bit++;
          if (mon_bit == DW) begin
            check(!mon_oe_bad, kind_req(e.kind), "output enable over slot", {63'd0, !mon_oe_bad}, 1);
            check(mon_acc === e.word, kind_req(e.kind), "slot word", mon_acc, e.word);
            check(cur_slot == e.slot, "R8", "current slot", cur_slot, e.slot);
            void'(exp_q.pop_front());
            mon_bit = 0;
            mon_oe_bad = 0;
            mon_slot++;
            if (mon_slot > frame_last) mon_act = 0;
          end
        end
      end else if (!fsync) begin
        check(!sd_oe && !in_ready, "R7", "idle outputs", {sd_oe, in_ready}, 0);
      end
      if (fsync) begin
        mon_act = 1;
        mon_bit = 0;
        mon_slot = 0;
        mon_oe_bad = 0;
      end
    end
  end

  task automatic wr_cfg(input bit bank, input int idx, input logic [31:0] data);
    @(posedge clk); #1;
    cfg_we = 1; cfg_bank = bank; cfg_idx = IW'(idx); cfg_data = data;
    if (bank) cmp_pend[idx*32 +: 32] = data;
    else      sel_pend[idx*32 +: 32] = data;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  // stop_after < 0: full frame; otherwise a new sync follows after that many slots
  task automatic run_frame(input int last, input int stop_after, input bit mc, input bit feed,
                           input bit chained, input bit mid_wr, input bit mid_bank,
                           input int mid_idx, input logic [31:0] mid_data);
    int n;
    exp_t e;
    logic [DW-1:0] w;
    if (!chained) begin
      @(posedge clk); #1;
    end
    sel_act = sel_pend;
    cmp_act = cmp_pend;
    n = (stop_after < 0) ? last + 1 : stop_after;
    for (int s = 0; s < n; s++) begin
      e.slot  = SW'(s);
      e.drive = mc && sel_act[s];
      if (!mc)            begin e.kind = 3'd4; e.word = '0; end
      else if (!sel_act[s]) begin e.kind = 3'd0; e.word = '0; end
      else if (!feed)     begin e.kind = 3'd3; e.word = '0; end
      else begin
        w = next_word();
        src_q.push_back(w);
        e.kind = cmp_act[s] ? 3'd2 : 3'd1;
        e.word = cmp_act[s] ? {mu_ref(w), 8'h00} : w;
      end
      exp_q.push_back(e);
    end
    refresh_src();
    frame_last = last;
    last_slot = SW'(last);
    mc_en = mc;
    fsync = 1;
    @(posedge clk); #1;
    fsync = 0;
    for (int c = 0; c < n * DW - 1; c++) begin
      @(posedge clk); #1;
      cfg_we = 0;
      if (mid_wr && c == 20) begin
        cfg_we = 1; cfg_bank = mid_bank; cfg_idx = IW'(mid_idx); cfg_data = mid_data;
        if (mid_bank) cmp_pend[mid_idx*32 +: 32] = mid_data;
        else          sel_pend[mid_idx*32 +: 32] = mid_data;
      end
    end
    if (stop_after < 0) begin
      @(posedge clk); #1;
      repeat (3) begin @(posedge clk); #1; end
      check(exp_q.size() == 0, "R2", "slots left unsent", exp_q.size(), 0);
      check(src_q.size() == 0, "R3", "samples left untaken", src_q.size(), 0);
      check(cur_slot == SW'(last), "R8", "slot held after frame", cur_slot, last);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!sd_oe && !sd_o && !in_ready && !uflow, "R1", "outputs after reset",
          {sd_oe, sd_o, in_ready, uflow}, 0);
    check(cur_slot == '0, "R1", "slot after reset", cur_slot, 0);
    mon_on = 1;

    // R3/R4/R5: mixed masks, channel 32 in the second word
    wr_cfg(0, 0, 32'h0000_00A5);
    wr_cfg(0, 1, 32'h0000_0001);
    wr_cfg(1, 0, 32'h0000_0024);
    run_frame(7, -1, 1, 1, 0, 0, 0, 0, '0);
    run_frame(33, -1, 1, 1, 0, 0, 0, 0, '0);

    // R10: write during a frame, effective next frame
    run_frame(7, -1, 1, 1, 0, 1, 0, 0, 32'h0000_00FF);
    run_frame(7, -1, 1, 1, 0, 0, 0, 0, '0);

    // R6: multichannel enable low
    run_frame(3, -1, 0, 1, 0, 0, 0, 0, '0);

    // R11: early sync after three slots
    run_frame(7, 3, 1, 1, 0, 0, 0, 0, '0);
    run_frame(5, -1, 1, 1, 1, 0, 0, 0, '0);

    // full 128-slot frame touching all mask words
    wr_cfg(0, 1, 32'h5555_5555);
    wr_cfg(0, 2, 32'hAAAA_AAAA);
    wr_cfg(0, 3, 32'hFFFF_FFFF);
    wr_cfg(1, 2, 32'hFFFF_FFFF);
    wr_cfg(1, 3, 32'h0F0F_0F0F);
    run_frame(127, -1, 1, 1, 0, 0, 0, 0, '0);

    // R9: starvation
    @(negedge clk);
    check(!uflow, "R9", "flag before starvation", uflow, 0);
    run_frame(7, -1, 1, 0, 0, 0, 0, 0, '0);
    @(negedge clk);
    check(uflow, "R9", "flag after starvation", uflow, 1);
    run_frame(7, -1, 1, 1, 0, 0, 0, 0, '0);
    @(negedge clk);
    check(uflow, "R9", "flag stays set", uflow, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule